// File: doc/BRIEF.md
# Masked ALU Flag Generator

This combinational unit produces the next condition-flag word after an integer add-type micro-operation. It takes the current flag word, a per-bit write mask, the operation result and both source operands, plus a two-bit operand size code. From these it forms the new flag word. Only the bits that the mask selects are recomputed. Every other bit of the input word reaches the output unchanged.

The recomputed conditions are carry, auxiliary (nibble) carry, parity, zero, sign and signed overflow. Two extra emulation flags are also produced. One is a second carry that uses the same carry calculation. The other is a second zero that uses the same zero test. Each emulation flag has its own mask bit, so a micro-operation can update it without touching the architectural flag of the same kind.

Carry is not taken from an adder output. It is recovered from the result and both operands at a single bit position. This lets the unit sit after any datapath that yields those three values.

There is no state machine and there is no clock. The unit has a single combinational state: the output follows the inputs in the same cycle.

Top module: `alu_flag_update`

## Requirements
- R1: Each bit of `flags_in` whose bit in `wr_mask` is 0 appears unchanged at the same position of `flags_out`. This applies to every bit of the word, including positions that hold no flag.
- R2: A flag bit whose mask bit is 1 is first cleared and is then set to 1 only when its condition holds. It never keeps its old value.
- R3: The carry flag is at bit 0. For msb = the top bit of the selected size, it is set when `(opa[msb]&opb[msb]) | ((opa[msb]|opb[msb]) & ~res[msb])` is 1.
- R4: The emulation carry flag is at bit 16. It uses the same carry calculation as R3, and it is written only when mask bit 16 is 1.
- R5: The auxiliary carry flag is at bit 4. It is the R3 carry expression evaluated at bit position 3.
- R6: The zero flag (bit 6) and the emulation zero flag (bit 17) are each set when every bit of `res` within the selected size is 0. Each is written only under its own mask bit.
- R7: The sign flag is at bit 7. It equals `res[msb]` at the selected size.
- R8: The overflow flag is at bit 11. It is set when `opa[msb]==opb[msb]` and `res[msb]!=opa[msb]`.
- R9: The parity flag is at bit 2. It is set when `res[7:0]` holds an even number of ones, whatever the size.
- R10: The size codes are 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes, so msb is 7, 15, 31 and 63 respectively. Bits of `res`, `opa` and `opb` above the selected size have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| flags_in | input | 32 | Current flag word |
| wr_mask | input | 32 | Per-bit write enable, same bit positions as the flags |
| res | input | 64 | Result of the operation |
| opa | input | 64 | First source operand |
| opb | input | 64 | Second source operand |
| size_sel | input | 2 | Operand size code (0:1B, 1:2B, 2:4B, 3:8B) |
| flags_out | output | 32 | Updated flag word |

## Verification
The assertions watch the following relations on every input change:
- pass-through of unmasked bits;
- agreement of the emulation carry and emulation zero flags with their architectural twins when both are written;
- the sign bit;
- the overflow bit;
- zero detection against a width mask rebuilt from the size code.

The carry expression, the nibble carry, parity limited to the low byte and the ignoring of upper operand bits are shown only by the bench's directed scenarios. Those scenarios compare full flag words against values worked out by hand for chosen operand pairs at every size.

// File: rtl/afg_pkg.sv
package afg_pkg;
    localparam int CF_POS  = 0;
    localparam int PF_POS  = 2;
    localparam int AF_POS  = 4;
    localparam int ZF_POS  = 6;
    localparam int SF_POS  = 7;
    localparam int OF_POS  = 11;
    localparam int ECF_POS = 16;
    localparam int EZF_POS = 17;
    localparam int FLAG_MIN_W = 18;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } op_size_e;

    typedef struct packed {
        logic carry;
        logic aux;
        logic parity;
        logic zero;
        logic sign;
        logic ovf;
    } cond_t;
endpackage

// File: rtl/afg_size_decode.sv
module afg_size_decode
    import afg_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  op_size_e           size,
    output logic [IDX_W-1:0]   msb_idx,
    output logic [DATA_W-1:0]  width_mask
);
    always_comb begin
        unique case (size)
            SZ_BYTE:  msb_idx = IDX_W'(7);
            SZ_HALF:  msb_idx = IDX_W'(15);
            SZ_WORD:  msb_idx = IDX_W'(31);
            SZ_DWORD: msb_idx = IDX_W'(DATA_W - 1);
            default:  msb_idx = IDX_W'(DATA_W - 1);
        endcase
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_wmask
        assign width_mask[i] = (IDX_W'(i) <= msb_idx);
    end
endmodule

// File: rtl/afg_cond.sv
module afg_cond
    import afg_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] res,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [IDX_W-1:0]  msb_idx,
    input  logic [DATA_W-1:0] width_mask,
    output cond_t             cond
);
    logic a_top, b_top, r_top;

    function automatic logic carry_at(input logic a, input logic b, input logic r);
        return (a & b) | ((a | b) & ~r);
    endfunction

    always_comb begin
        a_top = opa[msb_idx];
        b_top = opb[msb_idx];
        r_top = res[msb_idx];
        cond.carry  = carry_at(a_top, b_top, r_top);
        cond.aux    = carry_at(opa[3], opb[3], res[3]);
        cond.parity = ~(^res[7:0]);
        cond.zero   = ~|(res & width_mask);
        cond.sign   = r_top;
        cond.ovf    = (a_top == b_top) && (r_top != a_top);
    end
endmodule

// File: rtl/afg_merge.sv
module afg_merge
    import afg_pkg::*;
#(
    parameter int FLAG_W = 32
) (
    input  logic [FLAG_W-1:0] old_flags,
    input  logic [FLAG_W-1:0] mask,
    input  cond_t             cond,
    output logic [FLAG_W-1:0] new_flags
);
    logic [FLAG_W-1:0] cond_vec;

    always_comb begin
        cond_vec = '0;
        cond_vec[CF_POS]  = cond.carry;
        cond_vec[PF_POS]  = cond.parity;
        cond_vec[AF_POS]  = cond.aux;
        cond_vec[ZF_POS]  = cond.zero;
        cond_vec[SF_POS]  = cond.sign;
        cond_vec[OF_POS]  = cond.ovf;
        cond_vec[ECF_POS] = cond.carry;
        cond_vec[EZF_POS] = cond.zero;
    end

    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        assign new_flags[i] = mask[i] ? cond_vec[i] : old_flags[i];
    end
endmodule

// File: rtl/alu_flag_update.sv
module alu_flag_update
    import afg_pkg::*;
#(
    parameter int FLAG_W = 32,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [FLAG_W-1:0] wr_mask,
    input  logic [DATA_W-1:0] res,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [1:0]        size_sel,
    output logic [FLAG_W-1:0] flags_out
);
    logic [IDX_W-1:0]  msb_idx;
    logic [DATA_W-1:0] width_mask;
    cond_t             cond;

    afg_size_decode #(.DATA_W(DATA_W)) u_size (
        .size       (op_size_e'(size_sel)),
        .msb_idx    (msb_idx),
        .width_mask (width_mask)
    );

    afg_cond #(.DATA_W(DATA_W)) u_cond (
        .res        (res),
        .opa        (opa),
        .opb        (opb),
        .msb_idx    (msb_idx),
        .width_mask (width_mask),
        .cond       (cond)
    );

    afg_merge #(.FLAG_W(FLAG_W)) u_merge (
        .old_flags (flags_in),
        .mask      (wr_mask),
        .cond      (cond),
        .new_flags (flags_out)
    );
endmodule

// File: rtl/afg_checker.sv
module afg_checker
    import afg_pkg::*;
#(
    parameter int FLAG_W = 32,
    parameter int DATA_W = 64
) (
    input logic [FLAG_W-1:0] flags_in,
    input logic [FLAG_W-1:0] wr_mask,
    input logic [DATA_W-1:0] res,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic [1:0]        size_sel,
    input logic [FLAG_W-1:0] flags_out
);
    int unsigned top;
    logic [DATA_W-1:0] lowbits;

    always_comb begin
        top = (size_sel == 2'd0) ? 7 : (size_sel == 2'd1) ? 15 :
              (size_sel == 2'd2) ? 31 : DATA_W - 1;
        lowbits = (top >= DATA_W - 1) ? '1 : ((DATA_W'(1) << (top + 1)) - DATA_W'(1));
        if (!$isunknown({flags_in, wr_mask, res, opa, opb, size_sel})) begin
            assert_passthru_R1: assert (((flags_out ^ flags_in) & ~wr_mask) == '0);
            if (wr_mask[CF_POS] && wr_mask[ECF_POS])
                assert_ecf_twin_R4: assert (flags_out[ECF_POS] == flags_out[CF_POS]);
            if (wr_mask[ZF_POS] && wr_mask[EZF_POS])
                assert_ezf_twin_R6: assert (flags_out[EZF_POS] == flags_out[ZF_POS]);
            if (wr_mask[ZF_POS])
                assert_zero_R6: assert (flags_out[ZF_POS] == ((res & lowbits) == '0));
            if (wr_mask[SF_POS])
                assert_sign_R7: assert (flags_out[SF_POS] == res[top]);
            if (wr_mask[OF_POS])
                assert_ovf_R8: assert (flags_out[OF_POS] ==
                    ((opa[top] == opb[top]) && (res[top] != opa[top])));
        end
    end
endmodule

bind alu_flag_update afg_checker #(.FLAG_W(FLAG_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_alu_flag_update.sv
module sim_alu_flag_update;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] ALL = 32'h0003_08D5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] flags_in = '0, wr_mask = '0, flags_out;
    logic [63:0] res = '0, opa = '0, opb = '0;
    logic [1:0]  size_sel = '0;
    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_flag_update u0 (.flags_in(flags_in), .wr_mask(wr_mask), .res(res),
        .opa(opa), .opb(opb), .size_sel(size_sel), .flags_out(flags_out));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] f, input logic [31:0] m, input logic [1:0] sz,
                         input logic [63:0] a, input logic [63:0] b, input logic [63:0] r);
        @(negedge clk);
        flags_in = f; wr_mask = m; size_sel = sz; opa = a; opb = b; res = r;
        #1;
    endtask

    task automatic t_reset;
        chk("R1 reset state", flags_out, 32'h0);
    endtask

    task automatic t_passthru;
        apply(32'hDEAD_BEEF, 32'h0, 2'd0, 64'hFF, 64'h1, 64'h0);
        chk("R1 no mask", flags_out, 32'hDEAD_BEEF);
        apply(32'hFFFF_FFFF, 32'h40, 2'd0, 64'h1, 64'h1, 64'h2);
        chk("R2 ZF cleared alone", flags_out, 32'hFFFF_FFBF);
    endtask

    task automatic t_byte_wrap;
        apply(32'h0, ALL, 2'd0, 64'hFF, 64'h01, 64'h00);
        chk("R3 R5 R6 R9 byte wrap", flags_out, 32'h0003_0055);
        apply(32'h0, ALL, 2'd0, 64'h7F, 64'h01, 64'h80);
        chk("R7 R8 byte signed ovf", flags_out, 32'h0000_0890);
    endtask

    task automatic t_half;
        apply(32'h0, ALL, 2'd1, 64'hFFFF_FFFF_0000_8000, 64'hFFFF_FFFF_0000_8000,
              64'h1234_5678_0000_0000);
        chk("R10 half upper ignored", flags_out, 32'h0003_0845);
    endtask

    task automatic t_word;
        apply(32'h0, ALL, 2'd2, 64'h7FFF_FFFF, 64'h1, 64'hFFFF_FFFF_8000_0000);
        chk("R8 R10 word ovf", flags_out, 32'h0000_0894);
    endtask

    task automatic t_dword;
        apply(32'h0, ALL, 2'd3, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0);
        chk("R3 R10 dword carry", flags_out, 32'h0003_0845);
        apply(32'h0, 32'h40, 2'd3, 64'h0, 64'h0, 64'h1_0000_0000);
        chk("R6 dword upper nonzero", flags_out, 32'h0);
    endtask

    task automatic t_parity;
        apply(32'h0, 32'h4, 2'd3, 64'h1, 64'h2, 64'hFF00_0003);
        chk("R9 even parity low byte", flags_out, 32'h4);
        apply(32'hFFFF_FFFF, 32'h4, 2'd0, 64'h3, 64'h4, 64'h07);
        chk("R9 odd parity", flags_out, 32'hFFFF_FFFB);
    endtask

    task automatic t_emul;
        apply(32'h0, 32'h1_0000, 2'd0, 64'hFF, 64'h01, 64'h00);
        chk("R4 ECF alone", flags_out, 32'h0001_0000);
        apply(32'h0, 32'h2_0000, 2'd1, 64'h0, 64'h0, 64'h0);
        chk("R6 EZF alone", flags_out, 32'h0002_0000);
        apply(32'h0, 32'h1, 2'd1, 64'h00FF, 64'h0001, 64'h0100);
        chk("R3 no carry at half", flags_out, 32'h0);
        apply(32'h0, 32'h10, 2'd1, 64'h0008, 64'h0008, 64'h0010);
        chk("R5 aux carry", flags_out, 32'h10);
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_up();
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_passthru();
        t_byte_wrap();
        t_half();
        t_word();
        t_dword();
        t_parity();
        t_emul();
        finish_up();
    end
endmodule